// File: doc/BRIEF.md
# Scaled Counter Register Frames

This block is the memory-mapped register front end for a 64-bit scaled up-counter. It presents two 4 KB frames on one 32-bit request bus: address bit 12 picks the frame, 0 for the read/write control frame and 1 for the read-only status frame. Only the counter core is driven from here: its run enable, its scale enable, its 32-bit scale increment, and one-cycle pulses that load either 32-bit half of the count. The count itself comes back in on `count_i` and is returned on reads.

Every access is a full 32-bit word. A request is taken in the single cycle where `req_i` is high. Read data is registered and appears one cycle later, together with `rvalid_o`. Address bits [1:0] are ignored. Writes to read-only or unmapped words change nothing, and reads of unmapped words return zero.

Top module: `cnt_reg_frames`

## Requirements
- R1: After reset the control word reads 0, `enable_o` and `scale_en_o` are 0, and the scale register reads 0x0100_0000.
- R2: A write to control offset 0x000 stores data bits [4:0]. Bit 0 drives `enable_o` and bit 2 drives `scale_en_o`. Bits 1, 3 and 4 are the halt-on-debug, interrupt-mask and error-response-disable flags, which are only stored and read back.
- R3: Control-word bits [31:5] always read zero, and writing ones to them has no effect.
- R4: Control offset 0x004, the counter status word, always reads zero.
- R5: The low and high count halves read at control offsets 0x008/0x00C and at status offsets 0x000/0x004. The value returned is `count_i` as sampled in the request cycle.
- R6: A write to control offset 0x008 (low half) or 0x00C (high half) raises `cnt_ld_lo_o` or `cnt_ld_hi_o` for that cycle only, with `cnt_ld_data_o` equal to the write data. Writes to the status frame raise neither pulse.
- R7: Control offsets 0x010 and 0x0D0 reach one shared scale register. It may be written at any time, its value drives `scale_o`, and it reads back at either offset.
- R8: Control offset 0x0D4 reads zero, and writes to it leave the scale register unchanged.
- R9: Control offset 0x01C reads the constant 0x0002_0001. Bit 0 means scaling is implemented, and bits [18:17] = 1 mean clock select 1. Writes to it are ignored.
- R10: In each frame, offsets 0xFD0 to 0xFFC return twelve ID bytes in bits [7:0], one per word, in this order: 04,00,00,00, then P,B0,0B,00, then 0D,F0,05,B1. P is 0xBA in the control frame and 0xBB in the status frame.
- R11: Reads of unmapped offsets in either frame return zero, and writes to them change no register and raise no load pulse.
- R12: `rvalid_o` is high exactly in the cycle after a read request, and `rdata_o` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; top bit selects the status frame |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| count_i | input | 64 | Live count from the counter core |
| enable_o | output | 1 | Counter run enable |
| scale_en_o | output | 1 | Scaled increment enable |
| scale_o | output | 32 | Scale increment value |
| cnt_ld_lo_o | output | 1 | Load pulse for the low count half |
| cnt_ld_hi_o | output | 1 | Load pulse for the high count half |
| cnt_ld_data_o | output | 32 | Data for the count half load |

## Verification
Two things can meet at one clock edge: the registering of a count read, and the counter core moving the count to a new value. The bench sets a distinct `count_i` in each read cycle and replaces it with a different value in the very next cycle. It then judges that the read data matches the value from the request cycle, not the later one. It also writes the scale register while `enable_o` is high, to show that such a write is neither blocked nor lost.

// File: rtl/cntreg_pkg.sv
package cntreg_pkg;
  localparam int DW     = 32;
  localparam int CTRL_W = 5;
  localparam int CB_EN   = 0;
  localparam int CB_HDBG = 1;
  localparam int CB_SCEN = 2;
  localparam int CB_IMSK = 3;
  localparam int CB_EDIS = 4;

  localparam logic [31:0] OFF_CTRL   = 32'h000;
  localparam logic [31:0] OFF_STAT   = 32'h004;
  localparam logic [31:0] OFF_CLO    = 32'h008;
  localparam logic [31:0] OFF_CHI    = 32'h00C;
  localparam logic [31:0] OFF_SCL    = 32'h010;
  localparam logic [31:0] OFF_CAP    = 32'h01C;
  localparam logic [31:0] OFF_SCL_B  = 32'h0D0;
  localparam logic [31:0] OFF_SCL1   = 32'h0D4;
  localparam logic [31:0] OFF_ID_LO  = 32'hFD0;
  localparam logic [31:0] OFF_ID_HI  = 32'hFFC;
  localparam logic [31:0] CAP_WORD   = 32'h0002_0001;

  typedef enum logic [3:0] {
    K_NONE, K_CTRL, K_STAT, K_CNT_LO, K_CNT_HI,
    K_SCALE, K_SCALE1, K_CAP, K_IDB
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [3:0]  id_idx;
    logic        sts;
  } dec_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx, input logic sts);
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = sts ? 8'hBB : 8'hBA;
      4'd5:    id_byte = 8'hB0;
      4'd6:    id_byte = 8'h0B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cntreg_decode.sv
module cntreg_decode
  import cntreg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  localparam int OFF_W = ADDR_W - 1;

  logic [31:0] woff;
  logic [31:0] id_rel;
  logic        in_id;
  logic        sts;

  // word offset inside the frame, byte lanes ignored
  assign woff   = 32'(addr_i[OFF_W-1:0]) & ~32'h3;
  assign id_rel = woff - OFF_ID_LO;
  assign in_id  = (woff >= OFF_ID_LO) && (woff <= OFF_ID_HI);
  assign sts    = addr_i[ADDR_W-1];

  always_comb begin
    dec_o.sts    = sts;
    dec_o.id_idx = id_rel[5:2];
    dec_o.kind   = K_NONE;
    if (in_id) begin
      dec_o.kind = K_IDB;
    end else if (sts) begin
      if (woff == 32'h0)      dec_o.kind = K_CNT_LO;
      else if (woff == 32'h4) dec_o.kind = K_CNT_HI;
    end else begin
      case (woff)
        OFF_CTRL:  dec_o.kind = K_CTRL;
        OFF_STAT:  dec_o.kind = K_STAT;
        OFF_CLO:   dec_o.kind = K_CNT_LO;
        OFF_CHI:   dec_o.kind = K_CNT_HI;
        OFF_SCL,
        OFF_SCL_B: dec_o.kind = K_SCALE;
        OFF_SCL1:  dec_o.kind = K_SCALE1;
        OFF_CAP:   dec_o.kind = K_CAP;
        default:   dec_o.kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cntreg_ctrl.sv
module cntreg_ctrl
  import cntreg_pkg::*;
#(
  parameter logic [DW-1:0] SCALE_RST = 32'h0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_scale_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DW-1:0]     scale_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      scale_o <= SCALE_RST;
    end else begin
      if (wr_ctrl_i)  ctrl_o  <= wdata_i[CTRL_W-1:0];
      if (wr_scale_i) scale_o <= wdata_i;
    end
  end
endmodule

// File: rtl/cntreg_rdmux.sv
module cntreg_rdmux
  import cntreg_pkg::*;
(
  input  dec_t              dec_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DW-1:0]     scale_i,
  input  logic [2*DW-1:0]   count_i,
  output logic [DW-1:0]     rdata_o
);
  always_comb begin
    case (dec_i.kind)
      K_CTRL:   rdata_o = DW'(ctrl_i);
      K_CNT_LO: rdata_o = count_i[DW-1:0];
      K_CNT_HI: rdata_o = count_i[2*DW-1:DW];
      K_SCALE:  rdata_o = scale_i;
      K_CAP:    rdata_o = CAP_WORD;
      K_IDB:    rdata_o = DW'(id_byte(dec_i.id_idx, dec_i.sts));
      default:  rdata_o = '0;  // status word, second scale, unmapped
    endcase
  end
endmodule

// File: rtl/cnt_reg_frames.sv
module cnt_reg_frames
  import cntreg_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter logic [31:0] SCALE_RST = 32'h0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  input  logic [63:0]       count_i,
  output logic              enable_o,
  output logic              scale_en_o,
  output logic [31:0]       scale_o,
  output logic              cnt_ld_lo_o,
  output logic              cnt_ld_hi_o,
  output logic [31:0]       cnt_ld_data_o
);
  dec_t              dec;
  logic              acc_wr, acc_rd;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     rd_val;

  cntreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  // status frame is read-only
  assign acc_wr = req_i & we_i & ~dec.sts;
  assign acc_rd = req_i & ~we_i;

  cntreg_ctrl #(.SCALE_RST(SCALE_RST)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (acc_wr && dec.kind == K_CTRL),
    .wr_scale_i (acc_wr && dec.kind == K_SCALE),
    .wdata_i    (wdata_i),
    .ctrl_o     (ctrl_q),
    .scale_o    (scale_o)
  );

  cntreg_rdmux u_rd (
    .dec_i   (dec),
    .ctrl_i  (ctrl_q),
    .scale_i (scale_o),
    .count_i (count_i),
    .rdata_o (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= acc_rd;
      if (acc_rd) rdata_o <= rd_val;
    end
  end

  assign enable_o      = ctrl_q[CB_EN];
  assign scale_en_o    = ctrl_q[CB_SCEN];
  assign cnt_ld_lo_o   = acc_wr && dec.kind == K_CNT_LO;
  assign cnt_ld_hi_o   = acc_wr && dec.kind == K_CNT_HI;
  assign cnt_ld_data_o = wdata_i;
endmodule

// File: rtl/cnt_reg_frames_chk.sv
module cnt_reg_frames_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [63:0]       count_i,
  input logic [31:0]       rdata_o,
  input logic              rvalid_o,
  input logic              enable_o,
  input logic              scale_en_o,
  input logic [31:0]       scale_o,
  input logic              cnt_ld_lo_o,
  input logic              cnt_ld_hi_o
);
  logic [31:0] woff;
  logic        ctl_f, rd_req, wr_req;
  assign woff   = 32'(addr_i[ADDR_W-2:0]) & ~32'h3;
  assign ctl_f  = ~addr_i[ADDR_W-1];
  assign rd_req = req_i & ~we_i;
  assign wr_req = req_i & we_i;

  assert_rvalid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);
  assert_no_rvalid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);
  assert_ctrl_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && ctl_f && woff == 32'h0) |=>
      (enable_o == $past(wdata_i[0]) && scale_en_o == $past(wdata_i[2])));
  assert_scale_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && ctl_f && (woff == 32'h10 || woff == 32'hD0)) |=> scale_o == $past(wdata_i));
  assert_scale_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_req && ctl_f && (woff == 32'h10 || woff == 32'hD0)) |=> $stable(scale_o));
  assert_ld_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_ld_lo_o || cnt_ld_hi_o) |-> (wr_req && ctl_f));
  assert_ld_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cnt_ld_lo_o, cnt_ld_hi_o}) <= 1);
  assert_cnt_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !ctl_f && woff == 32'h0) |=> rdata_o == $past(count_i[31:0]));
  assert_cnt_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && ctl_f && woff == 32'hC) |=> rdata_o == $past(count_i[63:32]));
endmodule

bind cnt_reg_frames cnt_reg_frames_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .count_i     (count_i),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .enable_o    (enable_o),
  .scale_en_o  (scale_en_o),
  .scale_o     (scale_o),
  .cnt_ld_lo_o (cnt_ld_lo_o),
  .cnt_ld_hi_o (cnt_ld_hi_o)
);

// File: tb/sim_cnt_reg_frames.sv
module sim_cnt_reg_frames;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [63:0] count_i = '0;
  logic [31:0] rdata_o, scale_o, cnt_ld_data_o;
  logic        rvalid_o, enable_o, scale_en_o, cnt_ld_lo_o, cnt_ld_hi_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        s_lo, s_hi;
  logic [31:0] s_data;

  always #2 clk_i = ~clk_i;

  cnt_reg_frames u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected rvalid", 64'(rdata_o), 64'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata_o == e, t, 64'(rdata_o), 64'(e));
      end
    end
  end

  // called at a negedge; returns at the next negedge
  task automatic rd(input logic [12:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    #1;
    s_lo = cnt_ld_lo_o; s_hi = cnt_ld_hi_o; s_data = cnt_ld_data_o;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    chk(rvalid_o == 1'b0, "R12 no rvalid after write", 64'(rvalid_o), 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk(enable_o == 1'b0, "R1 enable after reset", 64'(enable_o), 64'h0);
    chk(scale_en_o == 1'b0, "R1 scale_en after reset", 64'(scale_en_o), 64'h0);
    chk(scale_o == 32'h0100_0000, "R1 scale_o after reset", 64'(scale_o), 64'h0100_0000);
    rd(13'h000, 32'h0, "R1 ctrl reset value");
    rd(13'h010, 32'h0100_0000, "R1 scale reset value");

    wr(13'h000, 32'hFFFF_FFFF);
    chk(enable_o == 1'b1, "R2 enable set", 64'(enable_o), 64'h1);
    chk(scale_en_o == 1'b1, "R2 scale_en set", 64'(scale_en_o), 64'h1);
    chk(!s_lo && !s_hi, "R6 ctrl write no load", 64'({s_lo, s_hi}), 64'h0);
    rd(13'h000, 32'h0000_001F, "R3 ctrl upper bits zero");
    wr(13'h000, 32'hFFFF_FFF2);
    chk(enable_o == 1'b0, "R2 enable cleared", 64'(enable_o), 64'h0);
    chk(scale_en_o == 1'b0, "R2 scale_en cleared", 64'(scale_en_o), 64'h0);
    rd(13'h000, 32'h0000_0012, "R3 ctrl bit5 ignored");
    wr(13'h000, 32'h0000_000D);
    rd(13'h000, 32'h0000_000D, "R2 ctrl readback");
    rd(13'h004, 32'h0, "R4 status word zero");

    // count sampled in request cycle; count moves right after
    count_i = 64'h89AB_CDEF_0123_4567;
    rd(13'h008, 32'h0123_4567, "R5 ctl count lo");
    count_i = 64'h1111_2222_3333_4444;
    rd(13'h00C, 32'h1111_2222, "R5 ctl count hi");
    count_i = 64'h5555_6666_7777_8888;
    rd(13'h1000, 32'h7777_8888, "R5 sts count lo");
    count_i = 64'h9999_AAAA_BBBB_CCCC;
    rd(13'h1004, 32'h9999_AAAA, "R5 sts count hi");
    count_i = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk_i);

    wr(13'h008, 32'hDEAD_BEEF);
    chk(s_lo && !s_hi && s_data == 32'hDEAD_BEEF, "R6 load low", 64'({s_lo, s_hi, s_data}), {30'h0, 2'b10, 32'hDEAD_BEEF});
    wr(13'h00C, 32'hCAFE_F00D);
    chk(!s_lo && s_hi && s_data == 32'hCAFE_F00D, "R6 load high", 64'({s_lo, s_hi, s_data}), {30'h0, 2'b01, 32'hCAFE_F00D});
    wr(13'h1000, 32'h1234_5678);
    chk(!s_lo && !s_hi, "R6 status frame write no load", 64'({s_lo, s_hi}), 64'h0);
    chk(!cnt_ld_lo_o && !cnt_ld_hi_o, "R6 pulse one cycle", 64'({cnt_ld_lo_o, cnt_ld_hi_o}), 64'h0);

    // enable is on here: scale write must still land
    chk(enable_o == 1'b1, "R7 enable on before scale write", 64'(enable_o), 64'h1);
    wr(13'h010, 32'h0080_0000);
    chk(scale_o == 32'h0080_0000, "R7 scale_o via 0x010", 64'(scale_o), 64'h0080_0000);
    rd(13'h0D0, 32'h0080_0000, "R7 alias read 0x0D0");
    wr(13'h0D0, 32'h0200_0003);
    rd(13'h010, 32'h0200_0003, "R7 alias read 0x010");
    wr(13'h0D4, 32'hAAAA_5555);
    rd(13'h0D4, 32'h0, "R8 second scale reads zero");
    chk(scale_o == 32'h0200_0003, "R8 scale unchanged", 64'(scale_o), 64'h0200_0003);

    wr(13'h01C, 32'hFFFF_FFFF);
    rd(13'h01C, 32'h0002_0001, "R9 capability word");
    rd(13'h101C, 32'h0, "R11 status frame capability offset unmapped");

    for (int i = 0; i < 12; i++) begin
      automatic logic [7:0] c;
      case (i)
        0: c = 8'h04; 4: c = 8'hBA; 5: c = 8'hB0; 6: c = 8'h0B;
        8: c = 8'h0D; 9: c = 8'hF0; 10: c = 8'h05; 11: c = 8'hB1;
        default: c = 8'h00;
      endcase
      rd(13'hFD0 + 13'(4 * i), 32'(c), $sformatf("R10 ctl id byte %0d", i));
      if (i == 4) c = 8'hBB;
      rd(13'h1FD0 + 13'(4 * i), 32'(c), $sformatf("R10 sts id byte %0d", i));
    end

    wr(13'h020, 32'hFFFF_FFFF);
    chk(!s_lo && !s_hi, "R11 unmapped write no load", 64'({s_lo, s_hi}), 64'h0);
    wr(13'h1010, 32'h0000_0000);
    wr(13'h1FD0, 32'h0000_00FF);
    rd(13'h020, 32'h0, "R11 unmapped read ctl 0x020");
    rd(13'h800, 32'h0, "R11 unmapped read ctl 0x800");
    rd(13'h1008, 32'h0, "R11 unmapped read sts 0x008");
    rd(13'h1FD0, 32'h04, "R11 sts id unaffected by write");
    rd(13'h000, 32'h0000_000D, "R11 ctrl unaffected");
    rd(13'h010, 32'h0200_0003, "R11 scale unaffected");
    @(negedge clk_i);
    @(negedge clk_i);
    chk(exp_q.size() == 0, "R12 all reads answered", 64'(exp_q.size()), 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule